// File: doc/BRIEF.md
# SPI Serial Memory Command Front-End

This block is the slave side of a byte-wide serial memory. It oversamples the four serial pins (clock, select, hold and data in) in the system clock domain, and shifts in an opcode byte and, for array accesses, a 16-bit address. It drives the serial output together with a separate output enable that a pad cell turns into a tri-state driver. Reads stream bytes out of an internal synchronous byte array. The array's write port belongs to the page-write engine next door.

Every other effect of a command goes out as a one-cycle strobe. Write-latch set and clear go to the protection logic. Status-register reads and writes go as requests. Each complete data byte of a write goes as a byte request, followed by a commit or a cancel strobe when select rises. The front-end keeps no status bits and decides nothing about protection. Its job is framing: the opcode, the address, the byte boundaries, the hold pause, and when a transfer counts as complete.

Top module: `spimem_frontend`

## Requirements
- R1: The block works with serial clock mode 0 (clock idles low) and mode 3 (clock idles high). Data in is sampled on rising clock edges and data out changes on falling edges. Every byte is sent most significant bit first.
- R2: The first byte after select falls is the opcode, and opcode bits 7..4 must be zero while bit 3 is ignored. Bits 2..0 select the command: 110 sets the write latch, 100 clears it, 101 reads status, 001 writes status, 011 reads the array and 010 writes the array. Set and clear each give one strobe when the opcode byte completes.
- R3: Any other opcode gives no strobe and takes no further data, and the output enable stays low until the next falling edge of select.
- R4: Array read and write take a 16-bit address after the opcode. Only the low log2(MEM_BYTES) bits are used, so bits 15..11 are ignored at the default size.
- R5: A read ignores data in after the address and returns the byte at that address. It then returns the following addresses, wrapping from the top address to 0.
- R6: A status read raises one request strobe and sends the status input byte, reloaded on every byte boundary, for as long as select stays low.
- R7: A status write gives a request strobe carrying the last complete data byte. The strobe comes only if select rises on a byte boundary.
- R8: An array write gives one byte request for each complete data byte. The request's address low log2(PAGE_BYTES) bits count up modulo the page size and the upper bits stay fixed. When select rises on a byte boundary after at least one byte, a commit strobe follows.
- R9: If select rises mid-byte during an array write that has issued bytes, a cancel strobe follows in place of the commit, and the partial byte is never issued.
- R10: While select is high, clock and data in have no effect and the output enable is low.
- R11: Hold taken low while the clock is low pauses the transfer: the output enable goes low, and clock edges and data in are ignored. Hold taken high while the clock is low resumes the transfer where it stopped.
- R12: After reset the output enable is low and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Select, active low |
| spi_si | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Pause request, active low |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for the data-out pad |
| status_in | input | 8 | Status byte from the protection block |
| wen_set | output | 1 | Write-latch set strobe |
| wen_clr | output | 1 | Write-latch clear strobe |
| stat_rd_req | output | 1 | Status read request strobe |
| stat_wr_req | output | 1 | Status write request strobe |
| stat_wdata | output | 8 | Byte for a status write |
| wbyte_req | output | 1 | Array write byte request strobe |
| wbyte_addr | output | log2(MEM_BYTES) | Address of the requested byte |
| wbyte_data | output | 8 | Data of the requested byte |
| wr_commit | output | 1 | Array write complete, start programming |
| wr_cancel | output | 1 | Array write aborted, drop staged bytes |
| ram_we | input | 1 | Array write enable from the page-write engine |
| ram_waddr | input | log2(MEM_BYTES) | Array write address |
| ram_wdata | input | 8 | Array write data |

## Verification
Every serial pin passes through two synchroniser flops, and the edge detector adds one comparison. So data out changes, and a strobe pulses, on the third system clock edge after a pin edge. Read data for a boundary is fetched on the cycle after that. The bench holds each serial clock half-period for five system clocks and samples data out and the enable on the last cycle of the low half, so data is always settled by the time it is read. After select rises, the bench waits ten system clocks before comparing its pulse counters, which covers the three-cycle strobe latency with margin.

// File: rtl/spimem_pkg.sv
// Shared types for the serial memory front-end: transfer phases and the
// decoded command set. Assumes opcode bits 7..4 must be zero and bit 3 is
// ignored.
package spimem_pkg;

    typedef enum logic [2:0] {
        PH_IDLE, PH_OPC, PH_ADDR, PH_RDAT, PH_WDAT, PH_SOUT, PH_SIN, PH_DEAD
    } phase_t;

    typedef enum logic [2:0] {
        CMD_NONE, CMD_WEN, CMD_WDIS, CMD_SRD, CMD_SWR, CMD_RD, CMD_WR
    } cmd_t;

    // Map the opcode's upper nibble and low three bits to a command.
    function automatic cmd_t decode_cmd(input logic [3:0] hi, input logic [2:0] lo);
        if (hi != 4'h0) return CMD_NONE;
        case (lo)
            3'b110:  return CMD_WEN;
            3'b100:  return CMD_WDIS;
            3'b101:  return CMD_SRD;
            3'b001:  return CMD_SWR;
            3'b011:  return CMD_RD;
            3'b010:  return CMD_WR;
            default: return CMD_NONE;
        endcase
    endfunction

endpackage

// File: rtl/spimem_sync.sv
// Two-flop synchroniser for a bundle of asynchronous pins, each with its own
// reset level. Assumes the pins change slower than the system clock.
module spimem_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic s1, s2;
        // Two-stage capture of one pin.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= RST_VAL[g];
                s2 <= RST_VAL[g];
            end else begin
                s1 <= d[g];
                s2 <= s1;
            end
        end
        assign q[g] = s2;
    end
endmodule

// File: rtl/spimem_ram.sv
// Byte-wide synchronous RAM: one write port and one read port whose data
// appears one cycle after the address. No reset on the contents.
module spimem_ram #(
    parameter int DEPTH = 2048,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    // Write and registered read.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/spimem_frontend.sv
// Serial memory command front-end. It oversamples the serial pins, frames the
// opcode, address and data bytes, streams array or status bytes out, and
// issues strobes to the protection and page-write blocks.
// Assumes clk is at least 4x the serial clock and the serial master meets
// setup and hold timing against the synchronised pins.
module spimem_frontend
    import spimem_pkg::*;
#(
    parameter int  MEM_BYTES  = 2048,
    parameter int  PAGE_BYTES = 32,
    localparam int AW         = $clog2(MEM_BYTES),
    localparam int PW         = $clog2(PAGE_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_sck,
    input  logic          spi_cs_n,
    input  logic          spi_si,
    input  logic          spi_hold_n,
    output logic          spi_so,
    output logic          spi_so_oe,
    input  logic [7:0]    status_in,
    output logic          wen_set,
    output logic          wen_clr,
    output logic          stat_rd_req,
    output logic          stat_wr_req,
    output logic [7:0]    stat_wdata,
    output logic          wbyte_req,
    output logic [AW-1:0] wbyte_addr,
    output logic [7:0]    wbyte_data,
    output logic          wr_commit,
    output logic          wr_cancel,
    input  logic          ram_we,
    input  logic [AW-1:0] ram_waddr,
    input  logic [7:0]    ram_wdata
);
    localparam int HIST = ((AW > 8) ? AW : 8) - 1;

    logic [3:0] pins_s;
    logic       sck_s, cs_n_s, hold_n_s, si_s;
    logic       sck_prev, cs_prev, held;
    logic       sck_rise, sck_fall, cs_fall, cs_rise, act_rise, act_fall;

    phase_t          phase;
    cmd_t            cmd_q, op_dec;
    logic [2:0]      bit_cnt;
    logic            addr_hi, ld, wr_any, sr_have, byte_done;
    logic [HIST-1:0] in_sr;
    logic [7:0]      nbyte, out_sr, ram_q;
    logic [AW-1:0]   cur_addr, raddr;

    spimem_sync #(.W(4), .RST_VAL(4'b0110)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({spi_sck, spi_cs_n, spi_hold_n, spi_si}), .q(pins_s)
    );
    assign {sck_s, cs_n_s, hold_n_s, si_s} = pins_s;

    // Previous levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
            cs_prev  <= 1'b1;
        end else begin
            sck_prev <= sck_s;
            cs_prev  <= cs_n_s;
        end
    end

    assign sck_rise = sck_s & ~sck_prev;
    assign sck_fall = ~sck_s & sck_prev;
    assign cs_fall  = ~cs_n_s & cs_prev;
    assign cs_rise  = cs_n_s & ~cs_prev;

    // Hold pause state: follows the hold pin only while the clock is low.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_s) held <= 1'b0;
        else if (!sck_s)      held <= ~hold_n_s;
    end

    assign act_rise  = sck_rise & ~held & ~cs_n_s;
    assign act_fall  = sck_fall & ~held & ~cs_n_s;
    assign byte_done = act_rise && (bit_cnt == 3'd7);
    assign nbyte     = {in_sr[6:0], si_s};
    assign op_dec    = decode_cmd(nbyte[7:4], nbyte[2:0]);
    assign raddr     = (phase == PH_ADDR) ? {in_sr[AW-2:0], si_s} : cur_addr;
    assign spi_so_oe = ~cs_n_s & ~held & (phase == PH_RDAT || phase == PH_SOUT);

    spimem_ram #(.DEPTH(MEM_BYTES), .AW(AW)) u_ram (
        .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
        .raddr(raddr), .rdata(ram_q)
    );

    // Transfer sequencer: shifting, framing, output loading and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;  cmd_q <= CMD_NONE;  bit_cnt <= '0;
            addr_hi <= 1'b0;   ld <= 1'b0;  wr_any <= 1'b0;  sr_have <= 1'b0;
            in_sr <= '0;  out_sr <= '0;  cur_addr <= '0;  spi_so <= 1'b0;
            wen_set <= 1'b0;  wen_clr <= 1'b0;  stat_rd_req <= 1'b0;
            stat_wr_req <= 1'b0;  stat_wdata <= '0;  wbyte_req <= 1'b0;
            wbyte_addr <= '0;  wbyte_data <= '0;  wr_commit <= 1'b0;  wr_cancel <= 1'b0;
        end else begin
            wen_set <= 1'b0;  wen_clr <= 1'b0;  stat_rd_req <= 1'b0;
            stat_wr_req <= 1'b0;  wbyte_req <= 1'b0;  wr_commit <= 1'b0;
            wr_cancel <= 1'b0;  ld <= 1'b0;
            if (act_rise) begin
                in_sr   <= {in_sr[HIST-2:0], si_s};
                bit_cnt <= bit_cnt + 3'd1;
            end
            if (ld) begin
                out_sr <= (phase == PH_SOUT) ? status_in : ram_q;
            end else if (act_fall && (phase == PH_RDAT || phase == PH_SOUT)) begin
                spi_so <= out_sr[7];
                out_sr <= {out_sr[6:0], 1'b0};
            end
            if (cs_fall) begin
                phase <= PH_OPC;  bit_cnt <= '0;  addr_hi <= 1'b0;
                wr_any <= 1'b0;   sr_have <= 1'b0;
            end else if (cs_rise) begin
                if (phase == PH_WDAT && wr_any) begin
                    if (bit_cnt == 3'd0) wr_commit <= 1'b1;
                    else                 wr_cancel <= 1'b1;
                end
                if (phase == PH_SIN && sr_have && bit_cnt == 3'd0) stat_wr_req <= 1'b1;
                phase <= PH_IDLE;
            end else if (byte_done) begin
                case (phase)
                    PH_OPC: begin
                        case (op_dec)
                            CMD_WEN:  begin wen_set <= 1'b1; phase <= PH_DEAD; end
                            CMD_WDIS: begin wen_clr <= 1'b1; phase <= PH_DEAD; end
                            CMD_SRD:  begin stat_rd_req <= 1'b1; ld <= 1'b1; phase <= PH_SOUT; end
                            CMD_SWR:  phase <= PH_SIN;
                            CMD_RD, CMD_WR: begin cmd_q <= op_dec; phase <= PH_ADDR; end
                            default:  phase <= PH_DEAD;
                        endcase
                    end
                    PH_ADDR: begin
                        if (!addr_hi) begin
                            addr_hi <= 1'b1;
                        end else if (cmd_q == CMD_RD) begin
                            cur_addr <= raddr + 1'b1;
                            ld       <= 1'b1;
                            phase    <= PH_RDAT;
                        end else begin
                            cur_addr <= raddr;
                            phase    <= PH_WDAT;
                        end
                    end
                    PH_RDAT: begin
                        cur_addr <= cur_addr + 1'b1;
                        ld       <= 1'b1;
                    end
                    PH_SOUT: ld <= 1'b1;
                    PH_SIN: begin
                        stat_wdata <= nbyte;
                        sr_have    <= 1'b1;
                    end
                    PH_WDAT: begin
                        wbyte_req  <= 1'b1;
                        wbyte_addr <= cur_addr;
                        wbyte_data <= nbyte;
                        wr_any     <= 1'b1;
                        cur_addr   <= {cur_addr[AW-1:PW], cur_addr[PW-1:0] + 1'b1};
                    end
                    default: ;
                endcase
            end
        end
    end

    // R10
    cs_idle_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_s && $past(cs_n_s)) |-> (phase == PH_IDLE));

    // R10
    cs_idle_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_s && $past(cs_n_s)) |-> ($stable(bit_cnt) && !wbyte_req));

    // R11
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held && $past(held)) |-> ($stable(bit_cnt) && $stable(out_sr)));

    // R3
    bad_op_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DEAD && $past(phase == PH_DEAD)) |-> (!spi_so_oe && !wbyte_req && !ld));

    // R9
    cancel_partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cancel |-> (!wr_commit && $past(bit_cnt) != 3'd0));

endmodule

// File: tb/tb_spimem_frontend.sv
module tb_spimem_frontend;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 5;
    localparam int MEMB       = 2048;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
    logic [7:0] status_in = 8'h00;
    logic ram_we = 1'b0;
    logic [10:0] ram_waddr = '0;
    logic [7:0] ram_wdata = '0;
    logic spi_so, spi_so_oe, wen_set, wen_clr, stat_rd_req, stat_wr_req;
    logic wbyte_req, wr_commit, wr_cancel;
    logic [7:0] stat_wdata, wbyte_data;
    logic [10:0] wbyte_addr;

    int n_chk = 0, n_fail = 0, oe_hits = 0;
    int c_set = 0, c_clr = 0, c_srd = 0, c_swr = 0, c_wb = 0, c_com = 0, c_can = 0;
    logic [7:0] last_sw = '0;
    logic [10:0] wl_a [64];
    logic [7:0] wl_d [64];

    always #(CLK_PERIOD / 2) clk = ~clk;

    spimem_frontend dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
        .spi_hold_n(hold_n), .spi_so(spi_so), .spi_so_oe(spi_so_oe),
        .status_in(status_in), .wen_set(wen_set), .wen_clr(wen_clr),
        .stat_rd_req(stat_rd_req), .stat_wr_req(stat_wr_req), .stat_wdata(stat_wdata),
        .wbyte_req(wbyte_req), .wbyte_addr(wbyte_addr), .wbyte_data(wbyte_data),
        .wr_commit(wr_commit), .wr_cancel(wr_cancel),
        .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata)
    );

    // Pulse counters and write-request log, observed at the ports.
    always @(posedge clk) begin
        if (wen_set)     c_set <= c_set + 1;
        if (wen_clr)     c_clr <= c_clr + 1;
        if (stat_rd_req) c_srd <= c_srd + 1;
        if (stat_wr_req) begin c_swr <= c_swr + 1; last_sw <= stat_wdata; end
        if (wr_commit)   c_com <= c_com + 1;
        if (wr_cancel)   c_can <= c_can + 1;
        if (wbyte_req) begin
            wl_a[c_wb % 64] <= wbyte_addr;
            wl_d[c_wb % 64] <= wbyte_data;
            c_wb <= c_wb + 1;
        end
    end

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + (a >>> 8) * 5 + 11) & 255);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_h();
        repeat (HALF) @(negedge clk);
    endtask

    task automatic cs_open(input bit m3);
        sck = m3;
        wait_h();
        cs_n = 1'b0;
        wait_h();
    endtask

    task automatic cs_close(input bit m3);
        if (!m3) begin sck = 1'b0; wait_h(); end
        cs_n = 1'b1;
        wait_h();
        wait_h();
    endtask

    task automatic xbits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nb; i--) begin
            sck = 1'b0;
            si = tx[i];
            wait_h();
            rx[i] = spi_so;
            if (spi_so_oe) oe_hits++;
            sck = 1'b1;
            wait_h();
        end
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        xbits(tx, 8, rx);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] rx;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R12: idle after reset
        check(spi_so_oe == 1'b0, "R12", "oe after reset", spi_so_oe, 0);
        check((c_set + c_clr + c_srd + c_swr + c_wb + c_com + c_can) == 0, "R12",
              "strobes after reset", c_set + c_clr + c_srd + c_swr + c_wb, 0);

        // Preload the array through its write port.
        for (int a = 0; a < MEMB; a++) begin
            ram_we = 1'b1;
            ram_waddr = 11'(a);
            ram_wdata = pat(a);
            @(negedge clk);
        end
        ram_we = 1'b0;

        // R2 R3: every opcode value followed by one more byte.
        status_in = 8'h5A;
        for (int op = 0; op < 256; op++) begin
            int s0, cl0, r0, w0, wb0, cm0, oe0;
            logic [5:0] got, exp;
            bit valid;
            logic [2:0] code;
            s0 = c_set; cl0 = c_clr; r0 = c_srd; w0 = c_swr; wb0 = c_wb;
            cm0 = c_com + c_can; oe0 = oe_hits;
            cs_open(1'b0);
            xbyte(8'(op), rx);
            xbyte(8'h00, rx);
            cs_close(1'b0);
            valid = (op / 16) == 0;
            code = 3'(op % 8);
            exp = {valid && code == 3'b110, valid && code == 3'b100,
                   valid && code == 3'b101, valid && code == 3'b001,
                   valid && code == 3'b101, 1'b0};
            got = {c_set - s0 == 1, c_clr - cl0 == 1, c_srd - r0 == 1, c_swr - w0 == 1,
                   oe_hits != oe0, (c_wb - wb0 + c_com + c_can - cm0) != 0};
            check(got == exp, (exp[5:1] == 0) ? "R3" : "R2", $sformatf("opcode %02h", op),
                  got, exp);
        end

        // R4 R5: reads from many start addresses, upper address bits varied.
        for (int k = 0; k < 32; k++) begin
            logic [15:0] s;
            s = 16'((k * 1237 + 3) & 16'hFFFF);
            cs_open(1'b0);
            xbyte((k % 2) ? 8'h0B : 8'h03, rx);
            xbyte(s[15:8], rx);
            xbyte(s[7:0], rx);
            for (int j = 0; j < 3; j++) begin
                xbyte(8'hFF, rx);
                check(rx == pat((int'(s) + j) % MEMB), "R4", $sformatf("read %04h+%0d", s, j),
                      rx, pat((int'(s) + j) % MEMB));
            end
            cs_close(1'b0);
        end

        // R1 R5: mode 3 read across the top of the array.
        cs_open(1'b1);
        xbyte(8'h03, rx);
        xbyte(8'hFF, rx);
        xbyte(8'hFE, rx);
        for (int j = 0; j < 4; j++) begin
            xbyte(8'h00, rx);
            check(rx == pat((2046 + j) % MEMB), "R1", $sformatf("mode3 wrap byte %0d", j),
                  rx, pat((2046 + j) % MEMB));
        end
        cs_close(1'b1);

        // R6: status read repeats the status input.
        begin
            int r0;
            r0 = c_srd;
            status_in = 8'hC3;
            cs_open(1'b1);
            xbyte(8'h0D, rx);
            for (int j = 0; j < 3; j++) begin
                xbyte(8'h00, rx);
                check(rx == 8'hC3, "R6", "status byte", rx, 8'hC3);
            end
            cs_close(1'b1);
            check(c_srd - r0 == 1, "R6", "status read strobes", c_srd - r0, 1);
        end

        // R7: status write, whole byte then partial byte.
        begin
            int w0;
            w0 = c_swr;
            cs_open(1'b0);
            xbyte(8'h01, rx);
            xbyte(8'hA5, rx);
            cs_close(1'b0);
            check(c_swr - w0 == 1 && last_sw == 8'hA5, "R7", "status write", last_sw, 8'hA5);
            w0 = c_swr;
            cs_open(1'b0);
            xbyte(8'h09, rx);
            xbits(8'h3C, 5, rx);
            cs_close(1'b0);
            check(c_swr - w0 == 0, "R7", "partial status write", c_swr - w0, 0);
        end

        // R8: 34-byte write rolls over within the page.
        begin
            int wb0, cm0, cn0;
            wb0 = c_wb; cm0 = c_com; cn0 = c_can;
            cs_open(1'b0);
            xbyte(8'h02, rx);
            xbyte(8'hF5, rx);
            xbyte(8'hE5, rx);
            for (int k = 0; k < 34; k++) xbyte(8'(k * 3 + 1), rx);
            cs_close(1'b0);
            check(c_wb - wb0 == 34, "R8", "byte requests", c_wb - wb0, 34);
            check(c_com - cm0 == 1 && c_can == cn0, "R8", "commit", c_com - cm0, 1);
            for (int k = 0; k < 34; k++) begin
                int ea;
                ea = (16'h05E5 & ~31) | ((5 + k) % 32);
                check(wl_a[(wb0 + k) % 64] == 11'(ea) && wl_d[(wb0 + k) % 64] == 8'(k * 3 + 1),
                      "R8", $sformatf("request %0d", k), wl_a[(wb0 + k) % 64], ea);
            end
        end

        // R9: select rises three bits into the second data byte.
        begin
            int wb0, cm0, cn0;
            wb0 = c_wb; cm0 = c_com; cn0 = c_can;
            cs_open(1'b0);
            xbyte(8'h02, rx);
            xbyte(8'h00, rx);
            xbyte(8'h10, rx);
            xbyte(8'h77, rx);
            xbits(8'hE0, 3, rx);
            cs_close(1'b0);
            check(c_wb - wb0 == 1 && wl_a[wb0 % 64] == 11'h010 && wl_d[wb0 % 64] == 8'h77,
                  "R9", "only whole byte issued", c_wb - wb0, 1);
            check(c_can - cn0 == 1 && c_com == cm0, "R9", "cancel not commit", c_can - cn0, 1);
        end

        // R10: clock and data toggle with select high.
        begin
            int tot0, oe0;
            tot0 = c_set + c_clr + c_srd + c_swr + c_wb + c_com + c_can;
            oe0 = oe_hits;
            for (int k = 0; k < 20; k++) begin
                sck = ~sck;
                si = k[1];
                wait_h();
                if (spi_so_oe) oe_hits++;
            end
            sck = 1'b0;
            wait_h();
            check(oe_hits == oe0, "R10", "oe while deselected", oe_hits - oe0, 0);
            check(c_set + c_clr + c_srd + c_swr + c_wb + c_com + c_can == tot0, "R10",
                  "strobes while deselected", c_set + c_clr + c_srd + c_swr + c_wb, tot0);
        end

        // R11: hold pause inside the first data byte of a read.
        begin
            logic [7:0] b0;
            cs_open(1'b0);
            xbyte(8'h03, rx);
            xbyte(8'h01, rx);
            xbyte(8'h23, rx);
            b0 = '0;
            for (int i = 7; i >= 0; i--) begin
                sck = 1'b0;
                si = 1'b0;
                wait_h();
                b0[i] = spi_so;
                if (i == 4) begin
                    hold_n = 1'b0;
                    wait_h();
                    check(spi_so_oe == 1'b0, "R11", "oe during hold", spi_so_oe, 0);
                    for (int t = 0; t < 3; t++) begin
                        sck = 1'b1; si = 1'b1; wait_h();
                        sck = 1'b0; si = 1'b0; wait_h();
                    end
                    check(spi_so_oe == 1'b0, "R11", "oe after toggles", spi_so_oe, 0);
                    hold_n = 1'b1;
                    wait_h();
                    check(spi_so_oe == 1'b1, "R11", "oe after resume", spi_so_oe, 1);
                end
                sck = 1'b1;
                wait_h();
            end
            check(b0 == pat(16'h123), "R11", "byte across hold", b0, pat(16'h123));
            xbyte(8'h00, rx);
            check(rx == pat(16'h124), "R11", "byte after hold", rx, pat(16'h124));
            cs_close(1'b0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule